// File: doc/BRIEF.md
# Masked Content-Addressable Match Array

This block is a content-addressable memory of parameterized depth. Each word is 64 bits wide, and the default depth is 64 entries. It accepts one command per clock on a flat, synchronous interface:

- write a word at an address;
- write a word into the lowest empty slot;
- read a word back together with its two-bit state;
- compare a key against every entry that is live;
- load one or both bit masks;
- overwrite the state of one entry.

Each entry carries a two-bit state code: empty, valid or skip. Only valid entries take part in a compare. A skip entry keeps its data but never matches.

Two mask registers can be selected for a command, singly or as their union. On a write, a set mask bit preserves the stored bit. On a compare, a set mask bit excludes that bit position. The compare result is the lowest matching index, registered together with a hit bit, and it holds until the next compare.

Two active-low cascade inputs let several arrays be chained into one larger table. The upstream match input suppresses the local hit and forces the chained match flag active. The upstream full input gates the chained full flag, so the last array in the chain reports a system-wide full condition.

Top module: `mcam`

## Requirements
- R1: After reset every entry is in state 00 (empty), both masks are zero, `errFlag` and `matchValid` are 0, and `fullFlagN` and `matchFlagN` are 1 while the cascade inputs are high.
- R2: A write by address (`cmdOp`=1) stores `cmdData` at `cmdAddr` and sets that entry's state to 01. A read (`cmdOp`=3) presents the word on `rdData` and its state on `rdState` one cycle later, with `rdValid` high for exactly that cycle.
- R3: On a write, every bit at which the selected mask is 1 keeps its stored value. `maskSel` 00 selects no mask, 01 selects mask A, 10 selects mask B, and 11 selects the OR of both masks.
- R4: A compare (`cmdOp`=4) matches an entry whose state is 01 and whose unmasked bits all equal `cmdData`. The hit and its address appear on `matchValid` and `matchAddr` in the next cycle and hold until the next compare. With no hit, `matchValid` is 0 and `matchFlagN` is 1.
- R5: When several entries match, `matchAddr` is the lowest matching index.
- R6: A set-state command (`cmdOp`=6) writes `cmdState` to the entry at `cmdAddr` and leaves its data unchanged. An entry in state 10 (skip) or 11 never matches a compare, but counts as occupied.
- R7: A write-to-next-free command (`cmdOp`=2) stores the masked word in the lowest-index entry whose state is 00 and sets that entry to 01.
- R8: `fullFlagN` is 0 exactly when no entry is in state 00 and `fullInN` is 0.
- R9: A write-to-next-free command issued when no entry is empty changes no entry and sets `errFlag`, which stays at 1 until reset.
- R10: When `matchInN` is 0, `matchValid` is 0 and `matchFlagN` is 0. When `matchInN` is 1, `matchFlagN` is the inverse of the registered local hit.
- R11: A load-mask command (`cmdOp`=5) copies `cmdData` into mask A when `maskSel[0]` is 1 and into mask B when `maskSel[1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Command code: 0 idle, 1 write addr, 2 write free, 3 read, 4 compare, 5 load mask, 6 set state |
| cmdAddr | input | AW | Entry address for write, read and set-state commands |
| cmdData | input | WIDTH | Write data, compare key or mask value |
| maskSel | input | 2 | Mask selection |
| cmdState | input | 2 | State code for the set-state command |
| matchInN | input | 1 | Cascade match from the higher-priority array, active low |
| fullInN | input | 1 | Cascade full from the higher-priority array, active low |
| rdData | output | WIDTH | Read word |
| rdState | output | 2 | State code of the read entry |
| rdValid | output | 1 | Read result present |
| matchValid | output | 1 | Local hit that the cascade has not suppressed |
| matchAddr | output | AW | Lowest matching index |
| matchFlagN | output | 1 | Chained match flag, active low |
| fullFlagN | output | 1 | Chained full flag, active low |
| errFlag | output | 1 | Sticky write-to-full error |

## Verification
The local compare result and the upstream match input meet in the same cycle. The bench holds `matchInN` low while it issues a compare whose key is known to hit. The hit must be hidden from `matchValid` while `matchFlagN` still goes low. When `matchInN` is released, the held local hit must reappear. Likewise, the write that fills the last empty slot and the upstream full input are combined: the chained full flag is checked with `fullInN` at each level both before and after that write.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
  localparam logic [2:0] OP_IDLE    = 3'd0;
  localparam logic [2:0] OP_WR_ADDR = 3'd1;
  localparam logic [2:0] OP_WR_FREE = 3'd2;
  localparam logic [2:0] OP_READ    = 3'd3;
  localparam logic [2:0] OP_CMP     = 3'd4;
  localparam logic [2:0] OP_LD_MASK = 3'd5;
  localparam logic [2:0] OP_SET_ST  = 3'd6;

  localparam logic [1:0] ST_EMPTY = 2'b00;
  localparam logic [1:0] ST_VALID = 2'b01;
  localparam logic [1:0] ST_SKIP  = 2'b10;

  typedef struct packed {
    logic wrAddr;
    logic wrFree;
    logic rd;
    logic cmp;
    logic ldMask;
    logic setSt;
  } strobeT;
endpackage

// File: rtl/mcam_ctrl.sv
module mcam_ctrl
  import mcam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cmdOp,
  input  logic       freeAvail,
  input  logic       localFull,
  input  logic       hitQ,
  input  logic       matchInN,
  input  logic       fullInN,
  output strobeT     strb,
  output logic       errFlag,
  output logic       matchValid,
  output logic       matchFlagN,
  output logic       fullFlagN
);

  always_comb begin
    strb = '0;
    case (cmdOp)
      OP_WR_ADDR: strb.wrAddr = 1'b1;
      OP_WR_FREE: strb.wrFree = freeAvail;
      OP_READ:    strb.rd     = 1'b1;
      OP_CMP:     strb.cmp    = 1'b1;
      OP_LD_MASK: strb.ldMask = 1'b1;
      OP_SET_ST:  strb.setSt  = 1'b1;
      default:    strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) errFlag <= 1'b0;
    else if (cmdOp == OP_WR_FREE && !freeAvail) errFlag <= 1'b1;
  end

  // cascade gating: upstream hit hides ours and forces the chain flag
  assign matchValid = hitQ & matchInN;
  assign matchFlagN = ~hitQ & matchInN;
  assign fullFlagN  = ~(localFull & ~fullInN);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R9
  AST_FULL_NO_FREE: assert property (@(posedge clk) disable iff (!rstN)
    localFull |-> !freeAvail); // R8
  AST_FREE_WR_OK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOp == OP_WR_FREE && localFull) |-> !strb.wrFree); // R9

endmodule

// File: rtl/mcam_array.sv
module mcam_array
  import mcam_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [AW-1:0]    cmdAddr,
  input  logic [WIDTH-1:0] cmdData,
  input  logic [1:0]       maskSel,
  input  logic [1:0]       cmdState,
  output logic [WIDTH-1:0] rdData,
  output logic [1:0]       rdState,
  output logic             rdValid,
  output logic             hitQ,
  output logic [AW-1:0]    hitAddrQ,
  output logic             freeAvail,
  output logic             localFull
);

  localparam logic [DEPTH-1:0] ONE_HOT0 = DEPTH'(1);

  logic [WIDTH-1:0] memQ [DEPTH];
  logic [1:0]       stQ  [DEPTH];
  logic [WIDTH-1:0] maskAQ, maskBQ, selMask, wrWord;
  logic [DEPTH-1:0] hitVec, emptyVec, occVec, lowMask;
  logic [AW-1:0]    hitAddr, freeAddr, tgtAddr;
  logic             anyHit;

  assign selMask = (maskSel[0] ? maskAQ : '0) | (maskSel[1] ? maskBQ : '0);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_entry
      assign hitVec[g]   = (stQ[g] == ST_VALID) &&
                           (((memQ[g] ^ cmdData) & ~selMask) == '0);
      assign emptyVec[g] = (stQ[g] == ST_EMPTY);
      assign occVec[g]   = (stQ[g] != ST_EMPTY);
    end
  endgenerate

  // lowest index wins: scan downward, last hit assigned stays
  always_comb begin
    hitAddr  = '0;
    freeAddr = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitVec[i])   hitAddr  = AW'(i);
      if (emptyVec[i]) freeAddr = AW'(i);
    end
  end

  assign anyHit    = |hitVec;
  assign freeAvail = |emptyVec;
  assign localFull = &occVec;
  assign lowMask   = (ONE_HOT0 << hitAddr) - ONE_HOT0;

  assign tgtAddr = strb.wrFree ? freeAddr : cmdAddr;
  assign wrWord  = (memQ[tgtAddr] & selMask) | (cmdData & ~selMask);

  always_ff @(posedge clk) begin
    if (strb.wrAddr || strb.wrFree) memQ[tgtAddr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stQ[i] <= ST_EMPTY;
      maskAQ   <= '0;
      maskBQ   <= '0;
      hitQ     <= 1'b0;
      hitAddrQ <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdState  <= ST_EMPTY;
    end else begin
      rdValid <= strb.rd;
      if (strb.wrAddr || strb.wrFree) stQ[tgtAddr] <= ST_VALID;
      if (strb.setSt) stQ[cmdAddr] <= cmdState;
      if (strb.ldMask && maskSel[0]) maskAQ <= cmdData;
      if (strb.ldMask && maskSel[1]) maskBQ <= cmdData;
      if (strb.rd) begin
        rdData  <= memQ[cmdAddr];
        rdState <= stQ[cmdAddr];
      end
      if (strb.cmp) begin
        hitQ     <= anyHit;
        hitAddrQ <= hitAddr;
      end
    end
  end

  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    freeAvail |-> stQ[freeAddr] == ST_EMPTY); // R7
  AST_FREE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFree |=> stQ[$past(freeAddr)] == ST_VALID); // R7
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> (hitVec[hitAddr] && (hitVec & lowMask) == '0)); // R5
  AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> stQ[hitAddr] == ST_VALID); // R6

endmodule

// File: rtl/mcam.sv
module mcam
  import mcam_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmdOp,
  input  logic [AW-1:0]    cmdAddr,
  input  logic [WIDTH-1:0] cmdData,
  input  logic [1:0]       maskSel,
  input  logic [1:0]       cmdState,
  input  logic             matchInN,
  input  logic             fullInN,
  output logic [WIDTH-1:0] rdData,
  output logic [1:0]       rdState,
  output logic             rdValid,
  output logic             matchValid,
  output logic [AW-1:0]    matchAddr,
  output logic             matchFlagN,
  output logic             fullFlagN,
  output logic             errFlag
);

  strobeT strb;
  logic   freeAvail, localFull, hitQ;

  mcam_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .freeAvail(freeAvail),
    .localFull(localFull), .hitQ(hitQ), .matchInN(matchInN),
    .fullInN(fullInN), .strb(strb), .errFlag(errFlag),
    .matchValid(matchValid), .matchFlagN(matchFlagN), .fullFlagN(fullFlagN)
  );

  mcam_array #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .maskSel(maskSel), .cmdState(cmdState),
    .rdData(rdData), .rdState(rdState), .rdValid(rdValid),
    .hitQ(hitQ), .hitAddrQ(matchAddr), .freeAvail(freeAvail),
    .localFull(localFull)
  );

endmodule

// File: tb/mcam_bench.sv
`timescale 1ns/100ps
module mcam_bench;
  localparam int W  = 64;
  localparam int D  = 64;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [W-1:0]  cmdData;
  logic [1:0]    maskSel, cmdState;
  logic          matchInN, fullInN;
  logic [W-1:0]  rdData;
  logic [1:0]    rdState;
  logic          rdValid, matchValid, matchFlagN, fullFlagN, errFlag;
  logic [AW-1:0] matchAddr;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] mData [D];
  logic [1:0]   mSt [D];
  logic [W-1:0] mMaskA = '0, mMaskB = '0;

  always #2.5 clk = ~clk;

  mcam #(.WIDTH(W), .DEPTH(D)) u_mcam (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .maskSel(maskSel), .cmdState(cmdState),
    .matchInN(matchInN), .fullInN(fullInN), .rdData(rdData),
    .rdState(rdState), .rdValid(rdValid), .matchValid(matchValid),
    .matchAddr(matchAddr), .matchFlagN(matchFlagN), .fullFlagN(fullFlagN),
    .errFlag(errFlag)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] selM(input logic [1:0] s);
    return (s[0] ? mMaskA : '0) | (s[1] ? mMaskB : '0);
  endfunction

  // drive at negedge, return at the next negedge with the bus idle
  task automatic issue(input logic [2:0] op, input int a, input logic [W-1:0] d,
                       input logic [1:0] ms, input logic [1:0] st);
    cmdOp = op; cmdAddr = AW'(a); cmdData = d; maskSel = ms; cmdState = st;
    @(negedge clk);
    cmdOp = 3'd0;
  endtask

  task automatic wrAddr(input int a, input logic [W-1:0] d, input logic [1:0] ms);
    logic [W-1:0] m = selM(ms);
    mData[a] = (mData[a] & m) | (d & ~m);
    mSt[a] = 2'b01;
    issue(3'd1, a, d, ms, 2'b00);
  endtask

  task automatic wrFree(input logic [W-1:0] d);
    int f = -1;
    for (int i = D - 1; i >= 0; i--) if (mSt[i] == 2'b00) f = i;
    if (f >= 0) begin
      mData[f] = d;
      mSt[f] = 2'b01;
    end
    issue(3'd2, 0, d, 2'b00, 2'b00);
  endtask

  task automatic rdChk(input string req, input int a);
    issue(3'd3, a, '0, 2'b00, 2'b00);
    chk(req, rdData, mData[a]);
    chk(req, W'(rdState), W'(mSt[a]));
    chk(req, W'(rdValid), 1);
  endtask

  task automatic cmpChk(input string req, input logic [W-1:0] key, input logic [1:0] ms,
                        input logic expHit, input int expAddr);
    issue(3'd4, 0, key, ms, 2'b00);
    chk(req, W'(matchValid), W'(expHit));
    chk(req, W'(matchFlagN), W'(!expHit));
    if (expHit) chk(req, W'(matchAddr), W'(expAddr));
  endtask

  task automatic t_reset;
    chk("R1 full", W'(fullFlagN), 1);
    chk("R1 match", W'(matchFlagN), 1);
    chk("R1 valid", W'(matchValid), 0);
    chk("R1 err", W'(errFlag), 0);
    issue(3'd3, 9, '0, 2'b00, 2'b00);
    chk("R1 state", W'(rdState), 0);
    cmpChk("R1 cmp empty", 64'h0, 2'b00, 1'b0, 0);
  endtask

  task automatic t_write_read;
    wrAddr(5, 64'h0123_4567_89AB_CDEF, 2'b00);
    rdChk("R2 read", 5);
    @(negedge clk);
    chk("R2 rdValid one cycle", W'(rdValid), 0);
  endtask

  task automatic t_mask_write;
    mMaskA = 64'hFFFF_0000_0000_0000;
    issue(3'd5, 0, mMaskA, 2'b01, 2'b00); // R11 load A
    wrAddr(5, 64'hAAAA_BBBB_CCCC_DDDD, 2'b01);
    rdChk("R3 mask A write", 5);
    mMaskB = 64'h0000_0000_0000_FFFF;
    issue(3'd5, 0, mMaskB, 2'b10, 2'b00); // R11 load B
    wrAddr(5, 64'h1111_2222_3333_4444, 2'b11);
    rdChk("R3 union write", 5);
    wrAddr(5, 64'h5555_6666_7777_8888, 2'b10);
    rdChk("R11 mask B kept", 5);
  endtask

  task automatic t_compare;
    wrAddr(7, 64'hCAFE_F00D_0000_0001, 2'b00);
    wrAddr(3, 64'hCAFE_F00D_0000_0001, 2'b00);
    cmpChk("R5 lowest of two", 64'hCAFE_F00D_0000_0001, 2'b00, 1'b1, 3);
    cmpChk("R4 miss", 64'hCAFE_F00D_0000_0002, 2'b00, 1'b0, 0);
    cmpChk("R4 masked bits ignored", 64'h1234_F00D_0000_0001, 2'b01, 1'b1, 3);
    @(negedge clk);
    chk("R4 held", W'(matchAddr), 3);
  endtask

  task automatic t_skip;
    mSt[3] = 2'b10;
    issue(3'd6, 3, 64'hFFFF, 2'b00, 2'b10);
    cmpChk("R6 skip excluded", 64'hCAFE_F00D_0000_0001, 2'b00, 1'b1, 7);
    rdChk("R6 skip data kept", 3);
    mSt[7] = 2'b11;
    issue(3'd6, 7, '0, 2'b00, 2'b11);
    cmpChk("R6 code 11 excluded", 64'hCAFE_F00D_0000_0001, 2'b00, 1'b0, 0);
  endtask

  task automatic t_free;
    wrFree(64'h0F0F_0F0F_0F0F_0F0F);
    rdChk("R7 first free", 0);
    wrFree(64'hF0F0_F0F0_F0F0_F0F0);
    rdChk("R7 second free", 1);
    cmpChk("R7 free word live", 64'hF0F0_F0F0_F0F0_F0F0, 2'b00, 1'b1, 1);
  endtask

  task automatic t_cascade;
    matchInN = 1'b0;
    issue(3'd4, 0, 64'h0F0F_0F0F_0F0F_0F0F, 2'b00, 2'b00);
    chk("R10 suppressed", W'(matchValid), 0);
    chk("R10 chain flag", W'(matchFlagN), 0);
    matchInN = 1'b1;
    #1;
    chk("R10 released", W'(matchValid), 1);
    chk("R10 released addr", W'(matchAddr), 0);
    cmpChk("R10 no hit", 64'h7777, 2'b00, 1'b0, 0);
    matchInN = 1'b0;
    #1;
    chk("R10 upstream only", W'(matchFlagN), 0);
    matchInN = 1'b1;
  endtask

  task automatic t_full;
    int left;
    for (int n = 0; n < D; n++) begin
      left = 0;
      for (int i = 0; i < D; i++) if (mSt[i] == 2'b00) left++;
      if (left > 1) wrFree(64'h1000 + W'(n));
    end
    fullInN = 1'b0;
    #1;
    chk("R8 one left", W'(fullFlagN), 1);
    wrFree(64'h2000);
    chk("R8 full", W'(fullFlagN), 0);
    fullInN = 1'b1;
    #1;
    chk("R8 upstream not full", W'(fullFlagN), 1);
    fullInN = 1'b0;
    chk("R9 no err yet", W'(errFlag), 0);
    wrFree(64'hDEAD_0000_0000_00FF);
    chk("R9 err set", W'(errFlag), 1);
    cmpChk("R9 word dropped", 64'hDEAD_0000_0000_00FF, 2'b00, 1'b0, 0);
    rdChk("R9 last entry kept", D - 1);
    chk("R9 err sticky", W'(errFlag), 1);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) begin mData[i] = '0; mSt[i] = 2'b00; end
    rstN = 1'b0; cmdOp = '0; cmdAddr = '0; cmdData = '0; maskSel = '0;
    cmdState = '0; matchInN = 1'b1; fullInN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_mask_write();
    t_compare();
    t_skip();
    t_free();
    t_cascade();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule